// File: doc/BRIEF.md
# Byte-Wide Passive Configuration Loader

This block sits on the host side of an SRAM-based programmable device and loads it over a byte-wide passive parallel link. It drives the device's active-low configuration request line low for a set time, then waits for the device's open-drain status line to come back high. Next it pulls bytes from a valid/ready source. It places each byte on an 8-bit data bus and produces a configuration clock edge for it. It keeps checking the device's completion line to learn when loading has finished. All timing is set through parameters counted in system-clock cycles.

A status fault during streaming triggers a fresh request pulse. A limited number of such retries is allowed. When the device reports completion, the loader sends a set number of extra clock cycles for initialisation. It then releases the data bus and parks the configuration clock low. A busy, done and error flag report progress to the host.

The state machine has ten named states:

| State | Behaviour |
|---|---|
| IDLE | Nothing running. |
| PULSE | Request line held low. |
| WAIT_STAT | Waiting for status to rise, under a timeout. |
| ST2CK | Guard delay after status rises. |
| FETCH | Byte handshake. |
| SETUP | Clock low, data on the bus. |
| HIGH | Clock high, data held. |
| INIT_LO | Clock low during the extra clocks. |
| INIT_HI | Clock high during the extra clocks. |
| DONE | Loading finished. |

Its transitions are:

- IDLE or DONE moves to PULSE on start.
- PULSE moves to WAIT_STAT when its timer expires.
- WAIT_STAT moves to ST2CK when status is high, or to IDLE on timeout.
- ST2CK moves to FETCH when its timer expires.
- FETCH moves to SETUP on a handshake, or to INIT_LO when the done line is high (straight to DONE if no extra clocks are configured).
- SETUP moves to HIGH, and HIGH moves to FETCH, each when its timer expires.
- INIT_LO moves to INIT_HI. INIT_HI moves back to INIT_LO, or to DONE after the last extra clock.
- A low status in ST2CK, FETCH, SETUP or HIGH is a fault. A fault moves to PULSE while retries remain, and to IDLE once they are used up.

Top module: `cfg_loader`

## Requirements
- R1: After reset the loader has these outputs: request line high, configuration clock low, data bus disabled and driven 0, and busy, done and error all low.
- R2: A start pulse drives the request line low for exactly PULSE_CYC cycles, and busy rises. A start while busy is ignored, so it produces no additional request pulse.
- R3: If status stays low for STAT_TO_CYC cycles after the request pulse, the loader sets error, returns to idle with done low, and issues no clock edge.
- R4: No configuration clock rising edge occurs while status is low. The first rising edge comes no earlier than ST2CK_CYC + SETUP_CYC cycles after status rises.
- R5: Each accepted byte (valid and ready both high on a clock edge) produces exactly one configuration clock rising edge. Bytes reach the device in acceptance order. Ready is high only while the loader waits for a byte, and the clock stays low while valid is low.
- R6: The data bus holds each byte for at least SETUP_CYC cycles before its rising edge. The byte stays unchanged while the clock is high, which lasts HOLD_CYC cycles.
- R7: A low status during streaming sets error and starts a new request pulse. At most MAX_RETRY such restarts happen. The next fault after that returns the loader to idle with done low, after 1 + MAX_RETRY pulses in total.
- R8: Once the done line is high, the loader accepts no further bytes and issues exactly INIT_CLKS more rising edges. It then asserts done, disables the data bus, parks the clock low and drops busy.
- R9: Error stays set until the next accepted start clears it. The fault path and the successful path can end with error and done both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a configuration run (ignored while busy) |
| src_data_i | input | 8 | Byte from the source |
| src_valid_i | input | 1 | Source byte valid |
| src_ready_o | output | 1 | Loader accepts a byte this cycle |
| dev_nstatus_i | input | 1 | Device status, low while resetting or on a fault |
| dev_done_i | input | 1 | Device completion line |
| cfg_req_n_o | output | 1 | Active-low configuration request to the device |
| dclk_o | output | 1 | Configuration clock |
| data_o | output | 8 | Configuration data bus |
| data_oe_o | output | 1 | Data bus drive enable |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run finished successfully |
| err_o | output | 1 | A timeout or fault occurred in the last run |

## Verification
The streaming path is swept over stream lengths 1 to 6 against three valid patterns: always valid, valid every second cycle, and valid every third cycle. The device releases status after a different delay in each case, and each case uses its own byte pattern. Comparing the received order and counting edges against accepted bytes separates a correct pause-on-invalid from one that drops or repeats bytes. The setup and hold counters on each edge separate correct phase timing from an edge issued too early. A status line that never releases isolates the timeout path. A single mid-stream fault and a fault that repeats forever tell a correct retry budget from one that is off by one or never stops. A start issued mid-run, followed by a clean run, shows that start is ignored while busy and that error is cleared.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT_STAT,
        ST_ST2CK,
        ST_FETCH,
        ST_SETUP,
        ST_HIGH,
        ST_INIT_LO,
        ST_INIT_HI,
        ST_DONE
    } ldr_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfg_tick_counter.sv
// Down counter reloaded on every state change; expired marks the last cycle
// of the current state's dwell.
module cfg_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cfg_event_counter.sv
// Up counter with synchronous clear; clear wins over increment.
module cfg_event_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (clr)  count <= '0;
        else if (inc)  count <= count + 1'b1;
    end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int PULSE_CYC = 26,     // request low time (>= 500 ns at 50 MHz)
    parameter int STAT_TO_CYC = 12500, // status release timeout (230 us + margin)
    parameter int ST2CK_CYC = 100,    // guard from status high to first clock
    parameter int SETUP_CYC = 2,      // clock-low phase with data stable
    parameter int HOLD_CYC = 2,       // clock-high phase with data held
    parameter int INIT_CLKS = 300,    // extra clocks after done line rises
    parameter int MAX_RETRY = 3       // restarts allowed on a stream fault
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] src_data_i,
    input  logic       src_valid_i,
    output logic       src_ready_o,
    input  logic       dev_nstatus_i,
    input  logic       dev_done_i,
    output logic       cfg_req_n_o,
    output logic       dclk_o,
    output logic [7:0] data_o,
    output logic       data_oe_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);
    localparam int unsigned TMAX = max_u(max_u(PULSE_CYC, STAT_TO_CYC),
                                         max_u(ST2CK_CYC, max_u(SETUP_CYC, HOLD_CYC)));
    localparam int TW = max_u(1, $clog2(TMAX + 1));
    localparam int RW = max_u(1, $clog2(MAX_RETRY + 1));
    localparam int IW = max_u(1, $clog2(INIT_CLKS + 1));
    localparam int INIT_LAST = (INIT_CLKS > 0) ? INIT_CLKS - 1 : 0;

    ldr_state_e state_q, state_d;

    logic          tick_exp;
    logic          tick_load;
    logic [TW-1:0] tick_val;
    logic [RW-1:0] retry_cnt;
    logic [IW-1:0] init_cnt;
    logic          start_ev;
    logic          fault_ev;
    logic          timeout_ev;
    logic          take_byte;
    logic          streaming;
    logic          err_q;
    logic [7:0]    byte_q;

    // ---------------- event decode ----------------
    assign start_ev   = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
    assign streaming  = (state_q == ST_ST2CK) || (state_q == ST_FETCH) ||
                        (state_q == ST_SETUP) || (state_q == ST_HIGH);
    assign fault_ev   = streaming && !dev_nstatus_i;
    assign timeout_ev = (state_q == ST_WAIT_STAT) && !dev_nstatus_i && tick_exp;
    assign take_byte  = src_ready_o && src_valid_i;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) state_d = ST_PULSE;
            end
            ST_PULSE: begin
                if (tick_exp) state_d = ST_WAIT_STAT;
            end
            ST_WAIT_STAT: begin
                if (dev_nstatus_i) state_d = ST_ST2CK;
                else if (tick_exp) state_d = ST_IDLE;
            end
            ST_ST2CK: begin
                if (tick_exp) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (dev_done_i)       state_d = (INIT_CLKS > 0) ? ST_INIT_LO : ST_DONE;
                else if (src_valid_i) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (tick_exp) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (tick_exp) state_d = ST_FETCH;
            end
            ST_INIT_LO: begin
                if (tick_exp) state_d = ST_INIT_HI;
            end
            ST_INIT_HI: begin
                if (tick_exp)
                    state_d = (init_cnt == IW'(INIT_LAST)) ? ST_DONE : ST_INIT_LO;
            end
            default: state_d = ST_IDLE;
        endcase
        // a status fault overrides every streaming transition
        if (fault_ev)
            state_d = (retry_cnt == RW'(MAX_RETRY)) ? ST_IDLE : ST_PULSE;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- dwell timer ----------------
    assign tick_load = (state_d != state_q);

    always_comb begin
        unique case (state_d)
            ST_PULSE:               tick_val = TW'(PULSE_CYC - 1);
            ST_WAIT_STAT:           tick_val = TW'(STAT_TO_CYC - 1);
            ST_ST2CK:               tick_val = TW'(ST2CK_CYC - 1);
            ST_SETUP, ST_INIT_LO:   tick_val = TW'(SETUP_CYC - 1);
            ST_HIGH, ST_INIT_HI:    tick_val = TW'(HOLD_CYC - 1);
            default:                tick_val = '0;
        endcase
    end

    cfg_tick_counter #(.W(TW)) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tick_load),
        .load_val (tick_val),
        .expired  (tick_exp)
    );

    // ---------------- retry and init-clock counters ----------------
    cfg_event_counter #(.W(RW)) retry_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_ev),
        .inc   (fault_ev && (retry_cnt != RW'(MAX_RETRY))),
        .count (retry_cnt)
    );

    cfg_event_counter #(.W(IW)) initclk_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_FETCH),
        .inc   ((state_q == ST_INIT_HI) && tick_exp),
        .count (init_cnt)
    );

    // ---------------- byte and error registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         byte_q <= '0;
        else if (take_byte) byte_q <= src_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      err_q <= 1'b0;
        else if (start_ev)               err_q <= 1'b0;
        else if (fault_ev || timeout_ev) err_q <= 1'b1;
    end

    // ---------------- Moore outputs ----------------
    always_comb begin
        cfg_req_n_o = 1'b1;
        dclk_o      = 1'b0;
        data_oe_o   = 1'b0;
        busy_o      = 1'b1;
        done_o      = 1'b0;
        src_ready_o = 1'b0;
        unique case (state_q)
            ST_IDLE:      busy_o = 1'b0;
            ST_DONE: begin
                busy_o = 1'b0;
                done_o = 1'b1;
            end
            ST_PULSE:     cfg_req_n_o = 1'b0;
            ST_WAIT_STAT: ;
            ST_ST2CK:     data_oe_o = 1'b1;
            ST_FETCH: begin
                data_oe_o   = 1'b1;
                src_ready_o = dev_nstatus_i && !dev_done_i;
            end
            ST_SETUP, ST_INIT_LO: data_oe_o = 1'b1;
            ST_HIGH, ST_INIT_HI: begin
                data_oe_o = 1'b1;
                dclk_o    = 1'b1;
            end
            default: busy_o = 1'b0;
        endcase
    end

    assign data_o = data_oe_o ? byte_q : 8'h00;
    assign err_o  = err_q;

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int PULSE_CYC = 26
) (
    input logic       clk,
    input logic       rst_n,
    input logic       src_ready_o,
    input logic       dev_nstatus_i,
    input logic       cfg_req_n_o,
    input logic       dclk_o,
    input logic [7:0] data_o,
    input logic       data_oe_o,
    input logic       busy_o,
    input logic       done_o
);
    int unsigned low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            low_cnt <= 0;
        else if (cfg_req_n_o)  low_cnt <= 0;
        else if (low_cnt < 32'hFFFF_FFFF) low_cnt <= low_cnt + 1;
    end

    // R1: outside a run the request line is released and the clock rests low
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cfg_req_n_o && !dclk_o));

    // R2: request pulse lasts at least PULSE_CYC cycles
    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req_n_o) |-> (low_cnt >= PULSE_CYC));

    // R4: a rising clock edge follows a cycle with status high
    p_no_edge_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> $past(dev_nstatus_i));

    // R5: bytes are accepted only with the bus driven and the clock low
    p_ready_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready_o |-> (data_oe_o && !dclk_o && cfg_req_n_o));

    // R6: data held while the clock stays high
    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_o && $past(dclk_o)) |-> $stable(data_o));

    // R8: finished state parks the clock and releases the bus
    p_done_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!dclk_o && !data_oe_o && !busy_o && cfg_req_n_o));
endmodule

bind cfg_loader cfg_loader_chk #(.PULSE_CYC(PULSE_CYC)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_ready_o   (src_ready_o),
    .dev_nstatus_i (dev_nstatus_i),
    .cfg_req_n_o   (cfg_req_n_o),
    .dclk_o        (dclk_o),
    .data_o        (data_o),
    .data_oe_o     (data_oe_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
);

// File: tb/cfg_loader_tb.sv
`timescale 1ns/1ps
module cfg_loader_tb_top;
    localparam int PULSE_CYC   = 4;
    localparam int STAT_TO_CYC = 40;
    localparam int ST2CK_CYC   = 3;
    localparam int SETUP_CYC   = 2;
    localparam int HOLD_CYC    = 2;
    localparam int INIT_CLKS   = 3;
    localparam int MAX_RETRY   = 2;
    localparam int WATCHDOG    = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] src_data_i = 8'h00;
    logic       src_valid_i = 1'b0;
    logic       src_ready_o;
    logic       dev_nstatus_i = 1'b0;
    logic       dev_done_i = 1'b0;
    logic       cfg_req_n_o, dclk_o, data_oe_o, busy_o, done_o, err_o;
    logic [7:0] data_o;

    always #10 clk = ~clk;   // 50 MHz

    cfg_loader #(
        .PULSE_CYC(PULSE_CYC), .STAT_TO_CYC(STAT_TO_CYC), .ST2CK_CYC(ST2CK_CYC),
        .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .INIT_CLKS(INIT_CLKS),
        .MAX_RETRY(MAX_RETRY)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_data_i(src_data_i), .src_valid_i(src_valid_i), .src_ready_o(src_ready_o),
        .dev_nstatus_i(dev_nstatus_i), .dev_done_i(dev_done_i),
        .cfg_req_n_o(cfg_req_n_o), .dclk_o(dclk_o), .data_o(data_o),
        .data_oe_o(data_oe_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int tests = 0;
    int fails = 0;

    // case configuration
    int n_bytes = 1, vmode = 1, rel_dly = 5, fault_at = 0, fault_times = 0, seed = 0;
    bit no_release = 1'b0;

    // device-model and measurement state
    int  rel_cnt = 0, rx = 0, faults_done = 0, stable_cnt = 0, cyc = 0;
    bit  faulted = 1'b0, dclk_prev = 1'b0, req_prev = 1'b1;
    logic [7:0] last_byte = 8'h00, data_prev = 8'h00;
    int  pulses, low_len, pulse_min, pulse_max, mism, setup_viol, hold_viol, extra;
    int  lowclk_viol, gap_cnt, gap_min, src_idx;
    bit  gap_run;

    function automatic logic [7:0] pat(input int i, input int s);
        return 8'((i * 29 + s * 13 + 7) & 255);
    endfunction

    task automatic clear_stats();
        pulses = 0; low_len = 0; pulse_min = 1 << 30; pulse_max = 0;
        mism = 0; setup_viol = 0; hold_viol = 0; extra = 0;
        lowclk_viol = 0; gap_cnt = 0; gap_min = 1 << 30; gap_run = 1'b0;
        faults_done = 0;
    endtask

    initial clear_stats();

    // source handshake counted on the active edge (DUT updates via NBA)
    always @(posedge clk) begin
        if (!cfg_req_n_o)                    src_idx <= 0;
        else if (src_valid_i && src_ready_o) src_idx <= src_idx + 1;
    end
    initial src_idx = 0;

    // device model and source drive on the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        src_valid_i = ((cyc % vmode) == 0);
        src_data_i  = pat(src_idx, seed);

        if (data_o == data_prev) stable_cnt = stable_cnt + 1;
        else                     stable_cnt = 0;
        data_prev = data_o;

        if (!cfg_req_n_o) begin
            if (req_prev) pulses = pulses + 1;
            low_len = low_len + 1;
            dev_nstatus_i = 1'b0; dev_done_i = 1'b0;
            rel_cnt = 0; rx = 0; faulted = 1'b0;
        end else begin
            if (!req_prev) begin
                if (low_len < pulse_min) pulse_min = low_len;
                if (low_len > pulse_max) pulse_max = low_len;
                low_len = 0;
            end
            if (!dev_nstatus_i && !faulted && !no_release) begin
                rel_cnt = rel_cnt + 1;
                if (rel_cnt >= rel_dly) begin
                    dev_nstatus_i = 1'b1; gap_run = 1'b1; gap_cnt = 0;
                end
            end else if (gap_run) gap_cnt = gap_cnt + 1;
        end

        if (dclk_o && !dclk_prev) begin
            if (!dev_nstatus_i) lowclk_viol = lowclk_viol + 1;
            if (gap_run) begin
                if (gap_cnt < gap_min) gap_min = gap_cnt;
                gap_run = 1'b0;
            end
            if (rx < n_bytes) begin
                if (data_o != pat(rx, seed)) mism = mism + 1;
                if (stable_cnt < SETUP_CYC) setup_viol = setup_viol + 1;
                last_byte = data_o;
                rx = rx + 1;
                if (rx == n_bytes) dev_done_i = 1'b1;
            end else extra = extra + 1;
        end
        if (!dclk_o && dclk_prev && data_oe_o && data_o != last_byte)
            hold_viol = hold_viol + 1;

        if (dev_nstatus_i && !dev_done_i && rx == fault_at && fault_at > 0 &&
            faults_done < fault_times) begin
            dev_nstatus_i = 1'b0; faulted = 1'b1; faults_done = faults_done + 1;
        end

        dclk_prev = dclk_o;
        req_prev  = cfg_req_n_o;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int n, input int vm, input int rel, input int fat,
                            input int ftimes, input bit norel, input int sd,
                            input bit poke_start);
        @(posedge clk); #2;
        n_bytes = n; vmode = vm; rel_dly = rel; fault_at = fat;
        fault_times = ftimes; no_release = norel; seed = sd;
        clear_stats();
        start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
        if (poke_start) begin
            repeat (PULSE_CYC + rel + 4) @(posedge clk);
            #2 start_i = 1'b1;
            @(posedge clk); #2 start_i = 1'b0;
        end
        while (busy_o) begin
            @(posedge clk); #2;
        end
        @(posedge clk); #2;
    endtask

    task automatic check_success(input int n);
        chk("R8", "done", done_o, 1);
        chk("R8", "busy", busy_o, 0);
        chk("R8", "dclk parked", dclk_o, 0);
        chk("R8", "bus released", data_oe_o, 0);
        chk("R8", "extra clocks", extra, INIT_CLKS);
        chk("R5", "order mismatches", mism, 0);
        chk("R5", "bytes accepted", src_idx, n);
        chk("R6", "setup violations", setup_viol, 0);
        chk("R6", "hold violations", hold_viol, 0);
        chk("R4", "edges with status low", lowclk_viol, 0);
        chk("R4", "guard gap ok", int'(gap_min >= ST2CK_CYC + SETUP_CYC), 1);
        chk("R2", "pulse min", pulse_min, PULSE_CYC);
        chk("R2", "pulse max", pulse_max, PULSE_CYC);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1", "req_n", cfg_req_n_o, 1);
        chk("R1", "dclk", dclk_o, 0);
        chk("R1", "oe", data_oe_o, 0);
        chk("R1", "data", data_o, 0);
        chk("R1", "busy", busy_o, 0);
        chk("R1", "done", done_o, 0);
        chk("R1", "err", err_o, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // sweep: stream length x valid pattern
        for (int n = 1; n <= 6; n++) begin
            for (int vm = 1; vm <= 3; vm++) begin
                run_case(n, vm, 5 + 3 * n, 0, 0, 1'b0, n * 3 + vm, 1'b0);
                check_success(n);
                chk("R9", "err clean run", err_o, 0);
                chk("R2", "single pulse", pulses, 1);
            end
        end

        // R3 timeout
        run_case(4, 1, 5, 0, 0, 1'b1, 1, 1'b0);
        chk("R3", "err", err_o, 1);
        chk("R3", "done", done_o, 0);
        chk("R3", "busy", busy_o, 0);
        chk("R3", "edges", extra + rx, 0);
        chk("R3", "req_n released", cfg_req_n_o, 1);

        // R7 single fault then success; R9 err and done together
        run_case(5, 1, 8, 2, 1, 1'b0, 9, 1'b0);
        chk("R7", "pulses after one fault", pulses, 2);
        chk("R7", "err after fault", err_o, 1);
        check_success(5);

        // R7 persistent fault: retries exhausted
        run_case(5, 2, 8, 1, 99, 1'b0, 4, 1'b0);
        chk("R7", "pulses when exhausted", pulses, 1 + MAX_RETRY);
        chk("R7", "done when exhausted", done_o, 0);
        chk("R7", "err when exhausted", err_o, 1);
        chk("R7", "busy when exhausted", busy_o, 0);

        // R2 start while busy ignored; R9 err cleared by new start
        run_case(6, 2, 6, 0, 0, 1'b0, 11, 1'b1);
        chk("R2", "start while busy ignored", pulses, 1);
        chk("R9", "err cleared by start", err_o, 0);
        check_success(6);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails = fails + 1;
        tests = tests + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule